// File: doc/BRIEF.md
# UART Transmitter with Break Generation

This block turns 8-bit characters into asynchronous serial frames. Each frame has one start bit, eight data bits sent least significant bit first, and one stop bit. Every bit lasts a fixed number of baud ticks, which arrive on a single-cycle strobe input. Characters enter through a write port into a four-entry buffer. The shifter takes the next character only at a character boundary, so frames can run back to back with no gap.

Software-facing logic sees three status outputs: buffer full, shifter-and-buffer empty, and break pending. It also sees an interrupt pulse, whose trigger is chosen by a 2-bit mode. A break request replaces the next frame with a start bit, twelve low bits and a stop bit. The request then clears itself.

The idle level of the line is set by an invert flag. The meaning of that flag swaps when the infrared-encode mode flag is set. Dropping the enable input stops the frame in flight, empties the buffer, cancels any break and releases the line.

Top module: `uart_tx_break`

## Requirements
- R1: A character frame is one start bit (raw 0), eight data bits LSB first, and one stop bit (raw 1). Each bit lasts 16 baud ticks. A character enters the shifter only when the shifter is idle or at the end of a stop bit.
- R2: The buffer holds 4 characters. `buf_full` is 1 exactly when 4 are held. A write made while the buffer is full, or while `tx_en` is 0, is dropped.
- R3: `shift_empty` is 1 when the shifter is idle and the buffer is empty. It is 1 after reset and 0 whenever a character is queued or shifting.
- R4: With `int_mode` = 2'b00, `int_pulse` goes high one cycle after each buffer-to-shifter transfer.
- R5: With `int_mode` = 2'b01, `int_pulse` goes high once when a stop bit ends with nothing left to send. In that cycle `shift_empty` is 1 and the line is idle.
- R6: With `int_mode` = 2'b10, `int_pulse` goes high only for a transfer that leaves the buffer empty; a write in the same cycle means it is not empty. With `int_mode` = 2'b11, `int_pulse` never goes high.
- R7: A `brk_req` pulse sets `brk_pending`. The next frame is then a start bit, 12 raw-0 bits and a stop bit. `brk_pending` clears when that stop bit ends. A request made during a frame waits for the frame to end. At a boundary, the break goes ahead of queued characters.
- R8: With `tx_en` = 0, the frame in flight is abandoned, the buffer is emptied and `brk_pending` is cleared. `tx_drive` is 0, and on re-enable no old character is sent.
- R9: The idle level is `~idle_inv` when `irda_mode` = 0 and `idle_inv` when `irda_mode` = 1. When the idle level is 0, the whole frame is sent inverted.
- R10: `int_pulse` is never high in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; 0 aborts and flushes |
| baud_tick | input | 1 | One-cycle baud strobe, 16 per bit |
| wr_valid | input | 1 | Write a character this cycle |
| wr_data | input | 8 | Character to write |
| brk_req | input | 1 | Pulse to request a break frame |
| int_mode | input | 2 | Interrupt condition select |
| irda_mode | input | 1 | Infrared-encode mode flag (polarity rule only) |
| idle_inv | input | 1 | Idle polarity invert flag |
| buf_full | output | 1 | Buffer holds 4 characters |
| shift_empty | output | 1 | Shifter idle and buffer empty |
| brk_pending | output | 1 | Break requested, not yet finished |
| int_pulse | output | 1 | One-cycle interrupt pulse |
| tx_out | output | 1 | Serial line level |
| tx_drive | output | 1 | Line driven by this block |

## Verification
After a write clock edge, the status outputs settle by the next cycle. The shifter takes the character at the edge after it lands in the buffer, and `int_pulse` follows that transfer edge by one cycle, so its interrupts are counted over whole bursts. Line bits are due every 16 baud ticks after the start edge, so the bench counts ticks and samples at the eighth tick of each bit. All outputs are read at falling clock edges, half a cycle after the edge that changed them. Abort and drop effects are checked one cycle after the enable falls. The bench then waits many ticks to show that no stale frame appears.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_BRK,
    TX_STOP
  } tx_state_e;

  localparam logic [1:0] IRQ_ON_LOAD  = 2'b00;
  localparam logic [1:0] IRQ_ON_DONE  = 2'b01;
  localparam logic [1:0] IRQ_ON_DRAIN = 2'b10;

  // Idle level of the line: the infrared flag reverses the meaning of invert.
  function automatic logic idle_level(input logic irda, input logic inv);
    return irda ? inv : ~inv;
  endfunction

  // Interrupt condition chosen by the mode code.
  function automatic logic irq_fire(input logic [1:0] mode, input logic load,
                                    input logic done, input logic drained);
    case (mode)
      IRQ_ON_LOAD:  return load;
      IRQ_ON_DONE:  return done;
      IRQ_ON_DRAIN: return load && drained;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         drained
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];
  // transfer that leaves nothing behind
  assign drained = pop_ok && (cnt == CW'(1)) && !push_ok;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) begin
        mem[wp] <= din;
        wp      <= wrap_inc(wp);
      end
      if (pop_ok) rp <= wrap_inc(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int W        = 8,
  parameter int TPB      = 16,
  parameter int BRK_BITS = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         baud_tick,
  input  logic         has_data,
  input  logic [W-1:0] din,
  input  logic         brk_pend,
  output logic         load_evt,
  output logic         brk_go,
  output logic         done_evt,
  output logic         brk_done,
  output logic         busy,
  output logic         raw_line
);
  localparam int NB = (W > BRK_BITS) ? W : BRK_BITS;
  localparam int BW = $clog2(NB);
  localparam int TW = $clog2(TPB);

  tx_state_e      state;
  logic [TW-1:0]  tcnt;
  logic [BW-1:0]  bcnt;
  logic [W-1:0]   sh;
  logic           in_brk;
  logic           bit_end, stop_end, boundary;

  assign bit_end  = baud_tick && (tcnt == TW'(TPB - 1));
  assign stop_end = (state == TX_STOP) && bit_end;
  assign boundary = enable && ((state == TX_IDLE) || stop_end);
  // a finishing break frame must not start another one from the same request
  assign brk_go   = boundary && brk_pend && !(stop_end && in_brk);
  assign load_evt = boundary && !brk_go && has_data;
  assign done_evt = enable && stop_end && !brk_go && !load_evt;
  assign brk_done = enable && stop_end && in_brk;
  assign busy     = (state != TX_IDLE);

  always_comb begin
    case (state)
      TX_START: raw_line = 1'b0;
      TX_DATA:  raw_line = sh[0];
      TX_BRK:   raw_line = 1'b0;
      default:  raw_line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state  <= TX_IDLE;
      tcnt   <= '0;
      bcnt   <= '0;
      in_brk <= 1'b0;
      sh     <= '0;
    end else if (brk_go) begin
      state  <= TX_START;
      tcnt   <= '0;
      in_brk <= 1'b1;
    end else if (load_evt) begin
      state  <= TX_START;
      tcnt   <= '0;
      in_brk <= 1'b0;
      sh     <= din;
    end else if (stop_end) begin
      state  <= TX_IDLE;
      tcnt   <= '0;
      in_brk <= 1'b0;
    end else if (busy && baud_tick) begin
      if (bit_end) begin
        tcnt <= '0;
        case (state)
          TX_START: begin
            state <= in_brk ? TX_BRK : TX_DATA;
            bcnt  <= '0;
          end
          TX_DATA: begin
            sh <= sh >> 1;
            if (bcnt == BW'(W - 1)) state <= TX_STOP;
            else                    bcnt  <= bcnt + 1'b1;
          end
          TX_BRK: begin
            if (bcnt == BW'(BRK_BITS - 1)) state <= TX_STOP;
            else                           bcnt  <= bcnt + 1'b1;
          end
          default: state <= state;
        endcase
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       load_evt,
  input  logic       done_evt,
  input  logic       drained,
  output logic       int_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) int_pulse <= 1'b0;
    else        int_pulse <= irq_fire(mode, load_evt, done_evt, drained);
  end
endmodule

// File: rtl/uart_tx_break.sv
module uart_tx_break
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int BUF_DEPTH     = 4,
  parameter int TICKS_PER_BIT = 16,
  parameter int BREAK_BITS    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              brk_req,
  input  logic [1:0]        int_mode,
  input  logic              irda_mode,
  input  logic              idle_inv,
  output logic              buf_full,
  output logic              shift_empty,
  output logic              brk_pending,
  output logic              int_pulse,
  output logic              tx_out,
  output logic              tx_drive
);
  logic [DATA_W-1:0] head;
  logic fifo_empty, drained;
  logic load_evt, brk_go, done_evt, brk_done, busy, raw_line;
  logic idle_lvl;

  uart_tx_fifo #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!tx_en),
    .push(wr_valid && tx_en), .din(wr_data),
    .pop(load_evt), .dout(head),
    .empty(fifo_empty), .full(buf_full), .drained(drained)
  );

  uart_tx_shifter #(.W(DATA_W), .TPB(TICKS_PER_BIT), .BRK_BITS(BREAK_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .enable(tx_en), .baud_tick(baud_tick),
    .has_data(!fifo_empty), .din(head), .brk_pend(brk_pending),
    .load_evt(load_evt), .brk_go(brk_go), .done_evt(done_evt),
    .brk_done(brk_done), .busy(busy), .raw_line(raw_line)
  );

  uart_tx_irq u_irq (
    .clk(clk), .rst_n(rst_n), .mode(int_mode),
    .load_evt(load_evt), .done_evt(done_evt), .drained(drained),
    .int_pulse(int_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) brk_pending <= 1'b0;
    else if (brk_req)     brk_pending <= 1'b1;
    else if (brk_done)    brk_pending <= 1'b0;
  end

  assign shift_empty = fifo_empty && !busy;
  assign idle_lvl    = idle_level(irda_mode, idle_inv);
  assign tx_out      = idle_lvl ? raw_line : ~raw_line;
  assign tx_drive    = tx_en;

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk
  import uart_tx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic [1:0] int_mode,
  input logic       irda_mode,
  input logic       idle_inv,
  input logic       buf_full,
  input logic       shift_empty,
  input logic       brk_pending,
  input logic       int_pulse,
  input logic       tx_out,
  input logic       load_evt
);
  AST_FULL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !shift_empty); // R2
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !shift_empty); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pulse && $past(int_mode) == 2'b01) |-> (tx_out == idle_level(irda_mode, idle_inv))); // R5
  AST_RSV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int_mode) == 2'b11) |-> !int_pulse); // R6
  AST_OFF_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (shift_empty && !buf_full && !brk_pending)); // R8
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && shift_empty) |-> (tx_out == idle_level(irda_mode, idle_inv))); // R9
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    int_pulse |=> !int_pulse); // R10
endmodule

bind uart_tx_break uart_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .int_mode(int_mode),
  .irda_mode(irda_mode), .idle_inv(idle_inv), .buf_full(buf_full),
  .shift_empty(shift_empty), .brk_pending(brk_pending),
  .int_pulse(int_pulse), .tx_out(tx_out), .load_evt(load_evt)
);

// File: tb/test_uart_tx_break.sv
`timescale 1ns/1ps
module test_uart_tx_break;
  logic clk = 1'b0;
  logic rst_n, tx_en, baud_tick, wr_valid, brk_req, irda_mode, idle_inv;
  logic [7:0] wr_data;
  logic [1:0] int_mode;
  logic buf_full, shift_empty, brk_pending, int_pulse, tx_out, tx_drive;
  logic [1:0] tdiv;
  int vectors = 0, misses = 0, irq_cnt = 0;
  logic last_pulse_empty = 1'b0;

  always #5 clk = ~clk;

  uart_tx_break i_uart_tx_break (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
    .wr_valid(wr_valid), .wr_data(wr_data), .brk_req(brk_req),
    .int_mode(int_mode), .irda_mode(irda_mode), .idle_inv(idle_inv),
    .buf_full(buf_full), .shift_empty(shift_empty), .brk_pending(brk_pending),
    .int_pulse(int_pulse), .tx_out(tx_out), .tx_drive(tx_drive)
  );

  // baud strobe: one cycle in four
  always @(posedge clk) begin
    if (!rst_n) begin tdiv <= 2'd0; baud_tick <= 1'b0; end
    else begin tdiv <= tdiv + 2'd1; baud_tick <= (tdiv == 2'd3); end
  end

  always @(negedge clk) if (int_pulse) begin
    irq_cnt++;
    last_pulse_empty = shift_empty;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (baud_tick !== 1'b1);
    end
    @(negedge clk);
  endtask

  function automatic logic raw_of(input logic idl);
    return idl ? tx_out : ~tx_out;
  endfunction

  task automatic rx_frame(input int nbits, input logic idl,
                          output logic [15:0] bits, output logic ok);
    int guard = 0;
    ok = 1'b1; bits = '0;
    while (tx_out === idl && guard < 4000) begin @(negedge clk); guard++; end
    if (guard >= 4000) begin ok = 1'b0; return; end
    wait_ticks(8);
    if (raw_of(idl) !== 1'b0) ok = 1'b0;
    for (int i = 0; i < nbits; i++) begin wait_ticks(16); bits[i] = raw_of(idl); end
    wait_ticks(16);
    if (raw_of(idl) !== 1'b1) ok = 1'b0;
  endtask

  task automatic expect_char(input string req, input logic [7:0] d, input logic idl);
    logic [15:0] b; logic ok;
    rx_frame(8, idl, b, ok);
    chk(req, "frame start/stop", ok, 1'b1);
    chk(req, "frame data", b[7:0], d);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_brk();
    brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R3", "shift_empty after reset", shift_empty, 1'b1);
    chk("R2", "buf_full after reset", buf_full, 1'b0);
    chk("R10", "int_pulse after reset", int_pulse, 1'b0);
    chk("R7", "brk_pending after reset", brk_pending, 1'b0);
    chk("R8", "tx_drive while disabled", tx_drive, 1'b0);
    wr(8'h11);
    @(negedge clk);
    chk("R2", "write while disabled dropped", shift_empty, 1'b1);
  endtask

  task automatic t_single();
    tx_en = 1'b1; @(negedge clk);
    chk("R8", "tx_drive when enabled", tx_drive, 1'b1);
    chk("R9", "idle high by default", tx_out, 1'b1);
    wr(8'hA5);
    chk("R3", "shift_empty with char queued", shift_empty, 1'b0);
    expect_char("R1", 8'hA5, 1'b1);
    wait_ticks(10);
    chk("R3", "shift_empty after frame", shift_empty, 1'b1);
  endtask

  task automatic t_full();
    wr(8'h01); @(negedge clk); @(negedge clk);
    wr(8'h02); wr(8'h03); wr(8'h04); wr(8'h05);
    chk("R2", "buf_full with 4 queued", buf_full, 1'b1);
    wr(8'h06);
    for (int k = 1; k <= 5; k++) expect_char("R2", 8'(k), 1'b1);
    wait_ticks(40);
    chk("R2", "dropped write never sent", shift_empty, 1'b1);
    chk("R2", "line idle after drop", tx_out, 1'b1);
  endtask

  task automatic t_irq(input logic [1:0] m, input int exp, input string req);
    int base;
    int_mode = m; @(negedge clk);
    base = irq_cnt;
    wr(8'h30); wr(8'h31); wr(8'h32);
    expect_char(req, 8'h30, 1'b1);
    expect_char(req, 8'h31, 1'b1);
    expect_char(req, 8'h32, 1'b1);
    wait_ticks(20);
    chk(req, "interrupt count", irq_cnt - base, exp);
    if (m == 2'b01) chk("R5", "pulse with shift_empty", last_pulse_empty, 1'b1);
  endtask

  task automatic t_break();
    logic [15:0] b; logic ok;
    int_mode = 2'b11;
    pulse_brk();
    chk("R7", "brk_pending set", brk_pending, 1'b1);
    rx_frame(12, 1'b1, b, ok);
    chk("R7", "break start/stop", ok, 1'b1);
    chk("R7", "break zeros", b[11:0], 12'h000);
    wait_ticks(10);
    chk("R7", "brk_pending self-clears", brk_pending, 1'b0);
    // request during a frame waits, then goes ahead of the queued char
    wr(8'h5A); wr(8'hC3);
    fork
      expect_char("R7", 8'h5A, 1'b1);
      begin wait_ticks(40); pulse_brk(); end
    join
    chk("R7", "break still pending at frame end", brk_pending, 1'b1);
    rx_frame(12, 1'b1, b, ok);
    chk("R7", "deferred break frame", {ok, b[11:0]}, {1'b1, 12'h000});
    expect_char("R7", 8'hC3, 1'b1);
    wait_ticks(10);
  endtask

  task automatic t_polarity();
    irda_mode = 1'b0; idle_inv = 1'b1; @(negedge clk);
    chk("R9", "irda0 inv1 idle", tx_out, 1'b0);
    irda_mode = 1'b1; idle_inv = 1'b0; @(negedge clk);
    chk("R9", "irda1 inv0 idle", tx_out, 1'b0);
    irda_mode = 1'b1; idle_inv = 1'b1; @(negedge clk);
    chk("R9", "irda1 inv1 idle", tx_out, 1'b1);
    irda_mode = 1'b0; idle_inv = 1'b1; @(negedge clk);
    wr(8'h3C);
    expect_char("R9", 8'h3C, 1'b0);
    wait_ticks(10);
    idle_inv = 1'b0; @(negedge clk);
  endtask

  task automatic t_abort();
    wr(8'h81); wr(8'h82); wr(8'h83);
    wait_ticks(50);
    pulse_brk();
    tx_en = 1'b0; @(negedge clk);
    chk("R8", "tx_drive released", tx_drive, 1'b0);
    chk("R8", "flushed on disable", shift_empty, 1'b1);
    chk("R8", "break cancelled", brk_pending, 1'b0);
    tx_en = 1'b1;
    wait_ticks(200);
    chk("R8", "no stale frame after re-enable", {shift_empty, tx_out}, 2'b11);
  endtask

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; wr_valid = 1'b0; wr_data = '0; brk_req = 1'b0;
    int_mode = 2'b00; irda_mode = 1'b0; idle_inv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    t_reset();
    t_single();
    t_full();
    t_irq(2'b00, 3, "R4");
    t_irq(2'b01, 1, "R5");
    t_irq(2'b10, 1, "R6");
    t_irq(2'b11, 0, "R6");
    t_break();
    t_polarity();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #2000000;
    vectors++; misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule